// File: doc/BRIEF.md
# Rewired Bank-Register Latch Mapper

This block models a bank-switching controller for a cartridge. The controller is a mapper chip with eight write-only 6-bit registers. The board wires it so that it acts as a simple latch. That latch picks one 32 KiB program bank and one 8 KiB pattern bank. The CPU writes to the $8000–$9FFF window. Address bit A0 set to zero loads a register index. A0 set to one stores data into the indexed register. The six CPU data lines reach the chip in a shuffled order.

On the board, the pattern-address line A12 is tied high, so only the four registers that serve the upper pattern half are ever consulted. Two bits of the chosen register go back into the chip's pattern-address A10/A11 inputs. This means the register in effect is chosen by its own top two bits. That loop is resolved without a combinational cycle: a slice register is in effect when its top bits name itself, the lowest such register wins, and register 2 is the fallback. Three bits of the register in effect drive the board lines PRG A15, CHR A13 and CHR A14. These outputs are registered.

The block runs on a fast system clock. It detects the falling edge of M2 by sampling M2 with that clock.

Top module: `latch_mapper`

## Requirements
- R1: A synchronous active-high reset clears the index latch, all eight registers and the three outputs to 0.
- R2: Board data line D5 drives chip bit 0, D2 drives bit 1, D0 drives bit 2, D1 drives bit 3, D3 drives bit 4, and D4 drives bit 5. As a result, board index values $01, $04, $21 and $24 select chip registers 4, 2, 5 and 3.
- R3: A write is taken on the clock edge that first sees M2 low after it was high. It needs ROM-select low, R/W low, A13 low and A14 low. With A0=0, chip bits 2:0 load the index latch. With A0=1, all six chip bits load the indexed register.
- R4: A cycle with R/W high changes no register.
- R5: A cycle with A13 high, A14 high or ROM-select high changes no register.
- R6: In the register in effect, chip bit 1 drives PRG A15, bit 2 drives CHR A13 and bit 3 drives CHR A14.
- R7: Chip registers 2 to 5 are the slice registers. Slice register 2+k is self-consistent when its bits 5:4 equal k. The lowest-numbered self-consistent slice register is in effect. If none is self-consistent, register 2 is in effect.
- R8: Board data $10, $01, $1A and $0B, each optionally ORed with $04, written to all four slice registers select pattern banks 0 to 3. Bank b gives CHR A13 = b[0] and CHR A14 = b[1], and the $04 sets PRG A15.
- R9: Writes to registers 0, 1, 6 and 7 never change the outputs.
- R10: The outputs change exactly one clock after a register changes, and hold while the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU M2 phase clock |
| romsel_n | input | 1 | ROM-select strobe, active low |
| rw | input | 1 | CPU read (1) / write (0) |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_d | input | 6 | Board data lines D5..D0 |
| prg_a15 | output | 1 | Board program address bit 15 |
| chr_a13 | output | 1 | Board pattern address bit 13 |
| chr_a14 | output | 1 | Board pattern address bit 14 |

## Verification
A register changes on the clock edge that first samples M2 low. The board outputs follow one edge later, so a result is due two clock edges after M2 falls. The bench holds M2 low and then high for two edges each. It waits three further edges before it samples at a falling clock edge. Every check therefore lands well after the outputs have settled and before the next bus cycle begins. The no-effect cases are checked the same way: a qualifier is broken on a write that would otherwise change the outputs, and the outputs are read back at the same point.

// File: rtl/latch_mapper_pkg.sv
package latch_mapper_pkg;
  localparam int DATA_W     = 6;
  localparam int NUM_REGS   = 8;
  localparam int SLICE_BASE = 2;
  localparam int NUM_SLICES = 4;
  localparam int OUT_LSB    = 1;
  localparam int OUT_W      = 3;

  typedef struct packed {
    logic chr_a14;
    logic chr_a13;
    logic prg_a15;
  } board_out_t;
endpackage

// File: rtl/bus_unscramble.sv
module bus_unscramble #(
  parameter int DW = 6
) (
  input  logic [DW-1:0] board_d,
  output logic [DW-1:0] chip_d
);
  // board line feeding each chip bit, chip bit 0 first
  localparam int MAP [6] = '{5, 2, 0, 1, 3, 4};

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign chip_d[i] = board_d[MAP[i]];
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int DW    = 6,
  parameter int NREG  = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic              wr_dat,
  input  logic [DW-1:0]     din,
  output logic [SEL_W-1:0]  sel_q,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0] bank_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else begin
      if (wr_sel) sel_q <= din[SEL_W-1:0];
      if (wr_dat) bank_q[sel_q] <= din;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign regs_flat[i*DW +: DW] = bank_q[i];
  end
endmodule

// File: rtl/loop_resolver.sv
module loop_resolver #(
  parameter int DW     = 6,
  parameter int NREG   = 8,
  parameter int BASE   = 2,
  parameter int NSLICE = 4,
  localparam int FB_W  = $clog2(NSLICE)
) (
  input  logic [NREG*DW-1:0] regs_flat,
  output logic [DW-1:0]      eff_word
);
  logic [NSLICE-1:0] self_ok;
  logic [FB_W-1:0]   pick;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    assign self_ok[k] =
      (regs_flat[(BASE+k)*DW + DW-FB_W +: FB_W] == FB_W'(k));
  end

  always_comb begin
    pick = '0;
    for (int k = NSLICE-1; k >= 0; k--) begin
      if (self_ok[k]) pick = FB_W'(k);
    end
  end

  assign eff_word = regs_flat[(BASE + int'(pick))*DW +: DW];
endmodule

// File: rtl/latch_mapper.sv
module latch_mapper
  import latch_mapper_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NREG   = NUM_REGS,
  parameter int BASE   = SLICE_BASE,
  parameter int NSLICE = NUM_SLICES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m2,
  input  logic          romsel_n,
  input  logic          rw,
  input  logic          cpu_a0,
  input  logic          cpu_a13,
  input  logic          cpu_a14,
  input  logic [DW-1:0] cpu_d,
  output logic          prg_a15,
  output logic          chr_a13,
  output logic          chr_a14
);
  localparam int SEL_W = $clog2(NREG);

  logic                m2_q;
  logic                strobe;
  logic [DW-1:0]       chip_d;
  logic [SEL_W-1:0]    sel_q;
  logic [NREG*DW-1:0]  regs_flat;
  logic [DW-1:0]       eff_word;
  board_out_t          out_q;

  always_ff @(posedge clk) begin
    if (rst) m2_q <= 1'b0;
    else     m2_q <= m2;
  end

  assign strobe = m2_q & ~m2 & ~romsel_n & ~rw & ~cpu_a13 & ~cpu_a14;

  bus_unscramble #(.DW(DW)) u_unscr (
    .board_d (cpu_d),
    .chip_d  (chip_d)
  );

  bank_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (strobe & ~cpu_a0),
    .wr_dat    (strobe & cpu_a0),
    .din       (chip_d),
    .sel_q     (sel_q),
    .regs_flat (regs_flat)
  );

  loop_resolver #(.DW(DW), .NREG(NREG), .BASE(BASE), .NSLICE(NSLICE)) u_res (
    .regs_flat (regs_flat),
    .eff_word  (eff_word)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= eff_word[OUT_LSB +: OUT_W];
  end

  assign prg_a15 = out_q.prg_a15;
  assign chr_a13 = out_q.chr_a13;
  assign chr_a14 = out_q.chr_a14;
endmodule

// File: rtl/latch_mapper_chk.sv
module latch_mapper_chk #(
  parameter int DW    = 6,
  parameter int NREG  = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst,
  input logic               m2,
  input logic               romsel_n,
  input logic               rw,
  input logic               cpu_a0,
  input logic               cpu_a13,
  input logic               cpu_a14,
  input logic               prg_a15,
  input logic               chr_a13,
  input logic               chr_a14,
  input logic [SEL_W-1:0]   sel_q,
  input logic [NREG*DW-1:0] regs_flat
);
  logic m2_seen;
  logic bus_wr;

  always_ff @(posedge clk) begin
    if (rst) m2_seen <= 1'b0;
    else     m2_seen <= m2;
  end

  assign bus_wr = m2_seen & ~m2 & ~romsel_n & ~rw & ~cpu_a13 & ~cpu_a14;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> ({prg_a15, chr_a13, chr_a14} == 3'b000 && regs_flat == '0 && sel_q == '0));

  a_r4_r5_regs_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(regs_flat));

  a_r3_sel_only_on_index_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && !cpu_a0) |=> $stable(sel_q));

  a_r7_reg2_self_drives: assert property (@(posedge clk) disable iff (rst)
    (regs_flat[2*DW+DW-2 +: 2] == 2'b00) |=>
      ({chr_a14, chr_a13, prg_a15} == $past(regs_flat[2*DW+1 +: 3])));

  a_r10_outputs_follow: assert property (@(posedge clk) disable iff (rst)
    $stable(regs_flat) |=> $stable({prg_a15, chr_a13, chr_a14}));
endmodule

bind latch_mapper latch_mapper_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .m2        (m2),
  .romsel_n  (romsel_n),
  .rw        (rw),
  .cpu_a0    (cpu_a0),
  .cpu_a13   (cpu_a13),
  .cpu_a14   (cpu_a14),
  .prg_a15   (prg_a15),
  .chr_a13   (chr_a13),
  .chr_a14   (chr_a14),
  .sel_q     (sel_q),
  .regs_flat (regs_flat)
);

// File: tb/tb_latch_mapper.sv
`timescale 1ns/1ps
module tb_latch_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m2 = 1'b1, romsel_n = 1'b1, rw = 1'b1;
  logic       cpu_a0 = 1'b0, cpu_a13 = 1'b0, cpu_a14 = 1'b0;
  logic [5:0] cpu_d = '0;
  logic       prg_a15, chr_a13, chr_a14;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  latch_mapper dut (
    .clk(clk), .rst(rst), .m2(m2), .romsel_n(romsel_n), .rw(rw),
    .cpu_a0(cpu_a0), .cpu_a13(cpu_a13), .cpu_a14(cpu_a14), .cpu_d(cpu_d),
    .prg_a15(prg_a15), .chr_a13(chr_a13), .chr_a14(chr_a14)
  );

  // {board data, expected prg_a15, chr_a13, chr_a14}  (R8)
  localparam logic [8:0] VEC [8] = '{
    {6'h10, 3'b000}, {6'h01, 3'b010}, {6'h1A, 3'b001}, {6'h0B, 3'b011},
    {6'h14, 3'b100}, {6'h05, 3'b110}, {6'h1E, 3'b101}, {6'h0F, 3'b111}
  };

  // board value that presents chip value c (R2 wiring)
  function automatic logic [5:0] to_board(input logic [5:0] c);
    logic [5:0] b;
    b[5] = c[0]; b[2] = c[1]; b[0] = c[2];
    b[1] = c[3]; b[3] = c[4]; b[4] = c[5];
    return b;
  endfunction

  task automatic bus_cycle(input logic a0, input logic a13, input logic a14,
                           input logic rs_n, input logic rwv, input logic [5:0] d);
    @(negedge clk);
    m2 = 1'b1; cpu_a0 = a0; cpu_a13 = a13; cpu_a14 = a14;
    romsel_n = rs_n; rw = rwv; cpu_d = d;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    m2 = 1'b1;
    @(negedge clk);
    romsel_n = 1'b1; rw = 1'b1;
  endtask

  task automatic wr(input logic [5:0] idx_board, input logic [5:0] d);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, idx_board);
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, d);
  endtask

  task automatic wr_all(input logic [5:0] d);
    wr(6'h01, d); wr(6'h04, d); wr(6'h21, d); wr(6'h24, d);
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    repeat (3) @(negedge clk);
    checks++;
    if ({prg_a15, chr_a13, chr_a14} !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, {prg_a15, chr_a13, chr_a14}, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 3'b000);

    for (int i = 0; i < 8; i++) begin
      wr_all(VEC[i][8:3]);
      check("R8 R6 R2 bank sequence", VEC[i][2:0]);
    end
    // now all slices hold chip $1E -> reg3 self-consistent, outputs 111

    wr(6'h24, 6'h08);
    check("R3 index+data to reg3", 3'b000);
    wr_all(6'h0F);
    check("R8 restore", 3'b111);

    bus_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h24);
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'h08);
    check("R4 read ignored", 3'b111);
    bus_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'h08);
    check("R5 A13 high ignored", 3'b111);
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'h08);
    check("R5 A14 high ignored", 3'b111);
    bus_cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'h08);
    check("R5 romsel high ignored", 3'b111);

    wr(6'h00, 6'h08);
    check("R9 reg0 write no effect", 3'b111);
    wr(to_board(6'd7), 6'h08);
    check("R9 reg7 write no effect", 3'b111);

    do_reset();
    check("R1 reset after load", 3'b000);

    // no slice self-consistent -> reg2 in effect
    wr(6'h04, to_board(6'b01_0100));
    wr(6'h24, to_board(6'b10_0000));
    wr(6'h01, to_board(6'b11_0000));
    wr(6'h21, to_board(6'b00_0000));
    check("R7 fallback to reg2", 3'b010);

    // reg3 and reg5 self-consistent -> reg3 wins
    wr(6'h04, to_board(6'b10_0000));
    wr(6'h24, to_board(6'b01_0010));
    wr(6'h01, to_board(6'b00_0000));
    wr(6'h21, to_board(6'b11_1000));
    check("R7 lowest self-consistent", 3'b100);

    // reg4 only self-consistent
    wr(6'h24, to_board(6'b00_0000));
    wr(6'h01, to_board(6'b10_1010));
    wr(6'h21, to_board(6'b00_0000));
    check("R7 reg4 in effect", 3'b101);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule